// File: doc/BRIEF.md
# Masked Priority Interrupt-Level Encoder

The block gathers thirteen level-sensitive interrupt requests from board peripherals. It copies their current levels into a 16-bit monitor word, and each source owns one fixed bit of that word. A 16-bit enable mask is held in a register that software reaches over a small address/data port. A source is pending when its monitor bit and the matching mask bit are both set. Among the pending sources, the one with the most urgent fixed rank is chosen. Its rank is inverted and driven to the processor as a 4-bit interrupt level.

The output is registered. Both the next monitor word and the next mask value are used to compute the next level, so the output settles one clock after an input changes or after a mask write. Mask bits 1 to 3 have no source behind them. They are stored and read back, but they never make anything pending.

Top module: `irl_prio_enc`

## Requirements
- R1: The monitor word is readable at byte offset 0x02. A source's bit holds the level that source had at the previous clock edge. Bits 1, 2 and 3 always read 0.
- R2: Sources map to monitor/mask bits and ranks as source index:bit:rank. The list is 0:9:1, 1:8:2, 2:14:9, 3:13:10, 4:12:3, 5:11:0, 6:10:4, 7:6:5, 8:5:6, 9:4:7, 10:7:8, 11:0:11, 12:15:12.
- R3: A source is pending only when its monitor bit and the same mask bit are both 1.
- R4: When several sources are pending, the one with the smallest rank is selected.
- R5: level_o equals the selected rank XOR 15. With nothing pending it is 0, and a rank-0 winner gives 15.
- R6: The mask register is at byte offset 0x00. All 16 bits are written and read back, including bits 1 to 3.
- R7: A mask write changes level_o one clock later, with no change needed on the source inputs.
- R8: While rst_ni is low, the mask and the monitor read 0 and level_o is 0. This holds even when sources are high.
- R9: The port decodes a 6-bit byte address (a 0x40 window). Reads at any offset other than 0x00 and 0x02 return 0. Writes to any offset other than 0x00, including the monitor, change nothing.
- R10: level_o is registered. It keeps its old value until the clock edge that follows an input change or mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 13 | Interrupt request levels, indexed as in R2 |
| addr_i | input | 6 | Register byte address |
| wr_i | input | 1 | Write strobe, sampled on the clock edge |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| level_o | output | 4 | Encoded interrupt level |

## Verification
The hardest case to reach from the ports is a mask write and a source change landing on the same edge. A correct design must combine both new values in a single cycle and not react to one of them a cycle late. The bench gets there with pseudo-random steps that drive a new source pattern and a mask write together. It also sweeps every pair of sources, to catch ranks whose order differs from their bit order, and samples the output just before each edge to confirm it does not change early.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int NSRC = 13;
  localparam int WW   = 16;
  localparam int LW   = 4;

  // source index -> monitor/mask bit, and priority rank (0 most urgent)
  localparam int SRC_BIT  [NSRC] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
  localparam int SRC_RANK [NSRC] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};

  function automatic logic [WW-1:0] used_bits();
    logic [WW-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[SRC_BIT[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irl_src_map.sv
module irl_src_map
  import irl_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int DW = WW
) (
  input  logic [N-1:0]  src_i,
  output logic [DW-1:0] mon_o
);
  always_comb begin
    mon_o = '0;
    for (int i = 0; i < N; i++) mon_o[SRC_BIT[i]] = src_i[i];
  end
endmodule

// File: rtl/irl_rank_sel.sv
module irl_rank_sel
  import irl_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int DW = WW,
  parameter int L  = LW
) (
  input  logic [DW-1:0] pend_i,
  output logic [L-1:0]  level_o
);
  localparam logic [L-1:0] IDLE = '1;
  localparam logic [DW-1:0] USED = used_bits();

  int best;
  logic unused_bits;
  assign unused_bits = ^(pend_i & ~USED);

  always_comb begin
    best = int'(IDLE);
    for (int i = 0; i < N; i++)
      if (pend_i[SRC_BIT[i]] && SRC_RANK[i] < best) best = SRC_RANK[i];
    level_o = L'(best) ^ IDLE;
  end
endmodule

// File: rtl/irl_regs.sv
module irl_regs #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter logic [AW-1:0] MASK_OFS = 6'h00,
  parameter logic [AW-1:0] MON_OFS  = 6'h02
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mon_q_i,
  output logic [DW-1:0] mask_q_o,
  output logic [DW-1:0] mask_d_o,
  output logic [DW-1:0] rdata_o
);
  logic mask_wr;
  assign mask_wr  = wr_i && (addr_i == MASK_OFS);
  // bypass so the level register sees the mask written on this edge
  assign mask_d_o = mask_wr ? wdata_i : mask_q_o;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mask_q_o <= '0;
    else         mask_q_o <= mask_d_o;

  always_comb begin
    unique case (addr_i)
      MASK_OFS: rdata_o = mask_q_o;
      MON_OFS:  rdata_o = mon_q_i;
      default:  rdata_o = '0;
    endcase
  end

  // R6
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == MASK_OFS) |=> mask_q_o == $past(wdata_i));

  // R9
  other_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != MASK_OFS) |=> $stable(mask_q_o));
endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
  import irl_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = WW,
  parameter int L  = LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [12:0]   src_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [L-1:0]  level_o
);
  logic [DW-1:0] mon_d, mon_q, mask_q, mask_d, pend_d;
  logic [L-1:0]  lvl_d;
  logic          valid_q;

  irl_src_map #(.N(NSRC), .DW(DW)) u_map (.src_i(src_i), .mon_o(mon_d));

  irl_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .mon_q_i(mon_q), .mask_q_o(mask_q),
    .mask_d_o(mask_d), .rdata_o(rdata_o)
  );

  assign pend_d = mon_d & mask_d;

  irl_rank_sel #(.N(NSRC), .DW(DW), .L(L)) u_sel (.pend_i(pend_d), .level_o(lvl_d));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mon_q   <= '0;
      level_o <= '0;
      valid_q <= 1'b0;
    end else begin
      mon_q   <= mon_d;
      level_o <= lvl_d;
      valid_q <= 1'b1;
    end

  // R1
  for (genvar g = 0; g < NSRC; g++) begin : g_mon_chk
    mon_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> mon_q[SRC_BIT[g]] == $past(src_i[g]));
  end

  // R4
  top_rank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i[5] && mask_d[SRC_BIT[5]]) |=> level_o == 4'hF);

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_d == '0) |=> level_o == '0);

  // R3
  lvl_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != '0) |-> ((mon_q & mask_q) != '0));
endmodule

// File: tb/sim_irl_prio_enc.sv
`timescale 1ns/1ps
module sim_irl_prio_enc;
  localparam int TB_BIT  [13] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
  localparam int TB_RANK [13] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] src = '0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  level;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irl_prio_enc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .level_o(level)
  );

  function automatic logic [3:0] model(input logic [12:0] s, input logic [15:0] m);
    int b = 15;
    for (int i = 0; i < 13; i++)
      if (s[i] && m[TB_BIT[i]] && TB_RANK[i] < b) b = TB_RANK[i];
    return 4'(b) ^ 4'hF;
  endfunction

  function automatic logic [15:0] mon_of(input logic [12:0] s);
    logic [15:0] v = '0;
    for (int i = 0; i < 13; i++) v[TB_BIT[i]] = s[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic read_reg(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // drive sources and optionally a mask write on a negedge, return at next negedge
  task automatic step(input logic [12:0] s, input logic do_wr, input logic [5:0] a,
                      input logic [15:0] d, input logic [3:0] prev, input string tag);
    @(negedge clk);
    src = s; wr = do_wr; addr = a; wdata = d;
    #1 check({tag, " R10 pre-edge"}, {12'h0, level}, {12'h0, prev});
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] mask;
    logic [12:0] s;
    logic [3:0]  exp_l;
    logic [31:0] lf;

    // R8: reset with sources high
    src = 13'h1FFF;
    repeat (3) @(negedge clk);
    check("R8 level in reset", {12'h0, level}, 16'h0);
    read_reg(6'h00, rd); check("R8 mask in reset", rd, 16'h0);
    read_reg(6'h02, rd); check("R8 monitor in reset", rd, 16'h0);
    src = '0;
    rst_ni = 1'b1;

    // R6: full mask write/read back, bits 1..3 stored
    step('0, 1'b1, 6'h00, 16'hFFFF, 4'h0, "R6");
    read_reg(6'h00, rd); check("R6 mask readback", rd, 16'hFFFF);
    mask = 16'hFFFF;
    exp_l = 4'h0;

    // R2 R5 R1: each source alone
    for (int i = 0; i < 13; i++) begin
      s = 13'(1) << i;
      step(s, 1'b0, 6'h00, 16'h0, exp_l, "R2");
      exp_l = model(s, mask);
      check("R2 R5 single source level", {12'h0, level}, {12'h0, 4'(TB_RANK[i]) ^ 4'hF});
      read_reg(6'h02, rd); check("R1 monitor bit", rd, mon_of(s));
    end

    // R4: every pair of sources
    for (int i = 0; i < 13; i++)
      for (int j = i + 1; j < 13; j++) begin
        s = (13'(1) << i) | (13'(1) << j);
        step(s, 1'b0, 6'h00, 16'h0, exp_l, "R4");
        exp_l = model(s, mask);
        check("R4 pair winner", {12'h0, level}, {12'h0, exp_l});
      end

    // R3 R7: all sources high, one mask bit at a time
    s = 13'h1FFF;
    step(s, 1'b0, 6'h00, 16'h0, exp_l, "R3");
    exp_l = model(s, mask);
    for (int b = 0; b < 16; b++) begin
      mask = 16'(1) << b;
      step(s, 1'b1, 6'h00, mask, exp_l, "R7");
      exp_l = model(s, mask);
      check("R3 R7 single mask bit", {12'h0, level}, {12'h0, exp_l});
      if (b >= 1 && b <= 3) check("R3 unattached bit gives idle", {12'h0, level}, 16'h0);
    end
    read_reg(6'h02, rd); check("R1 monitor all high", rd, 16'hFFF1);

    // R7: mask-only change with sources held
    mask = 16'h0000;
    step(s, 1'b1, 6'h00, mask, exp_l, "R7");
    exp_l = 4'h0;
    check("R7 mask cleared", {12'h0, level}, 16'h0);
    mask = 16'h0200;
    step(s, 1'b1, 6'h00, mask, exp_l, "R7");
    exp_l = model(s, mask);
    check("R7 mask enables source 0", {12'h0, level}, 16'h000E);

    // R3 R4 R5 R7: pseudo-random sources and masks changing together
    lf = 32'hACE1_1234;
    for (int k = 0; k < 300; k++) begin
      for (int t = 0; t < 32; t++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      s = lf[12:0];
      if (lf[31]) mask = lf[30:15];
      step(s, lf[31], 6'h00, lf[30:15], exp_l, "R4");
      exp_l = model(s, mask);
      check("R4 R5 random level", {12'h0, level}, {12'h0, exp_l});
    end
    read_reg(6'h00, rd); check("R6 mask after random", rd, mask);

    // R9: unimplemented offsets read 0, writes ignored
    mask = 16'h5A5A;
    step(s, 1'b1, 6'h00, mask, exp_l, "R9");
    exp_l = model(s, mask);
    for (int a = 1; a < 64; a++) begin
      if (a != 2) begin
        read_reg(6'(a), rd); check("R9 unimplemented read", rd, 16'h0);
      end
      step(s, 1'b1, 6'(a), 16'hFFFF, exp_l, "R9");
      read_reg(6'h00, rd); check("R9 mask unchanged", rd, mask);
      check("R9 level unchanged", {12'h0, level}, {12'h0, exp_l});
    end
    read_reg(6'h02, rd); check("R9 monitor write ignored", rd, mon_of(s));

    // R8: asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1 check("R8 level after reset", {12'h0, level}, 16'h0);
    read_reg(6'h00, rd); check("R8 mask after reset", rd, 16'h0);
    read_reg(6'h02, rd); check("R8 monitor after reset", rd, 16'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(13'h1FFF, 1'b0, 6'h00, 16'h0, 4'h0, "R8");
    check("R8 masked after reset", {12'h0, level}, 16'h0);

    finish_run();
  end
endmodule